// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a blocking, read-only lookup cache placed between a requester and a slower word-wide memory. Each request carries a block address; one block holds one data word. The low address bits pick a set (block address modulo the number of sets), and the remaining high bits form the tag. The set holds two ways, each with its own valid flag, tag and data word, and both tags are compared at once, so the requested block may live in either way.

A hit answers in the same cycle as the request. A miss starts a fetch on the memory port, which uses a valid/ready handshake. When the memory answers, the word goes to the requester and is written into a victim way in that same cycle. The victim is an empty way if the set has one (way 0 before way 1), otherwise the way marked by the set's single least-recently-used bit. Only one request is in flight at a time: the requester keeps its request up until it sees `rsp_ready`, then presents the next one.

Top module: `assoc2_rd_cache`

## Requirements
- R1: While reset is low, and right after it is released, `rsp_ready` and `mem_valid` are low, and every way of every set is empty and every LRU bit is 0, so the first access to any address after reset is a miss.
- R2: The set is `req_addr` modulo `SETS` (the low log2(SETS) bits) and the tag is the remaining high bits. Two addresses that differ only in the tag share a set and can be held together, one in each way.
- R3: A request in the idle state that matches a valid way raises `rsp_ready` and `rsp_hit` in that same cycle, with `rsp_data` equal to the word earlier fetched for that address, and issues no memory request.
- R4: A request that misses keeps `rsp_ready` low. From the next cycle on, `mem_valid` is high with `mem_addr` equal to the requested block address, and both stay unchanged until `mem_ready` is seen.
- R5: In the cycle where `mem_valid` and `mem_ready` are both high, `rsp_ready` is high, `rsp_hit` is low and `rsp_data` equals `mem_rdata`. The word and its tag are stored, and the controller is idle again in the next cycle.
- R6: The fill goes to way 0 if it is empty, otherwise to way 1 if it is empty, otherwise to the way named by the set's LRU bit (0 means way 0, 1 means way 1).
- R7: Every hit and every fill sets the LRU bit of that set to the way that was not just used.
- R8: With 2 sets and a 4-bit block address, the block sequence 0, 8, 0, 6, 8 after reset gives miss, miss, hit, miss, miss: block 6 displaces block 8, and the last access to 8 displaces block 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request present, held until `rsp_ready` |
| req_addr | input | ADDR_W | Block address of the request |
| rsp_ready | output | 1 | Request completed this cycle |
| rsp_hit | output | 1 | Completed request was a hit |
| rsp_data | output | DATA_W | Word returned with `rsp_ready` |
| mem_valid | output | 1 | Memory fetch request |
| mem_addr | output | ADDR_W | Block address being fetched |
| mem_ready | input | 1 | Memory word is present on `mem_rdata` |
| mem_rdata | input | DATA_W | Word returned by the memory |

## Verification
The hardest case to reach from the ports is a set with both ways valid and its LRU bit in a known state, followed by a third tag aimed at that set. Only the right victim choice leaves the correct survivor to hit on later. The bench runs a small setup (2 sets, 3-bit tags) with a pseudo-random address stream, so both ways fill within a few accesses and conflicts are frequent. It also varies the memory latency from zero to three cycles, and keeps its own model of valid, tag and LRU state to predict every hit, miss and returned word.

// File: rtl/assoc2_pkg.sv
package assoc2_pkg;
  localparam int unsigned NWAYS = 2;

  typedef enum logic {
    CTL_IDLE  = 1'b0,
    CTL_FETCH = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/assoc2_way_bank.sv
// One way of the cache: valid, tag and data per set, with its tag comparator.
module assoc2_way_bank #(
  parameter int unsigned SETS   = 16,
  parameter int unsigned SET_W  = 4,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  rd_set,
  input  logic [TAG_W-1:0]  cmp_tag,
  output logic              rd_valid,
  output logic              match,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [SETS-1:0]   vld_q, vld_d;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [DATA_W-1:0] data_q [SETS];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_set] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set]  <= wr_tag;
      data_q[wr_set] <= wr_data;
    end
  end

  assign rd_valid = vld_q[rd_set];
  assign match    = rd_valid && (tag_q[rd_set] == cmp_tag);
  assign rd_data  = data_q[rd_set];

  // R6
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_set)]);
endmodule

// File: rtl/assoc2_lru_pick.sv
// Per-set LRU bit and victim selection (empty way first, then LRU).
module assoc2_lru_pick #(
  parameter int unsigned SETS  = 16,
  parameter int unsigned SET_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] look_set,
  input  logic             look_v0,
  input  logic             look_v1,
  output logic             victim,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic             touch_way
);
  logic [SETS-1:0] lru_q, lru_d;

  always_comb begin
    lru_d = lru_q;
    if (touch_en) lru_d[touch_set] = ~touch_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  always_comb begin
    if (!look_v0)      victim = 1'b0;
    else if (!look_v1) victim = 1'b1;
    else               victim = lru_q[look_set];
  end

  // R7
  lru_points_away_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (lru_q[$past(touch_set)] != $past(touch_way)));
endmodule

// File: rtl/assoc2_rd_cache.sv
// Blocking read-only cache, two ways per set, one word per block.
module assoc2_rd_cache
  import assoc2_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned SETS   = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_ready,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int unsigned SET_W = $clog2(SETS);
  localparam int unsigned TAG_W = ADDR_W - SET_W;

  ctl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] fadr_q, fadr_d;
  logic              fway_q, fway_d;

  logic [SET_W-1:0]  look_set, fill_set;
  logic [TAG_W-1:0]  look_tag, fill_tag;
  logic [NWAYS-1:0]  way_match, way_valid;
  logic [DATA_W-1:0] way_data [NWAYS];
  logic              lookup, any_hit, fill, victim;

  assign look_set = req_addr[SET_W-1:0];
  assign look_tag = req_addr[ADDR_W-1:SET_W];
  assign fill_set = fadr_q[SET_W-1:0];
  assign fill_tag = fadr_q[ADDR_W-1:SET_W];

  assign lookup  = (state_q == CTL_IDLE) && req_valid;
  assign any_hit = |way_match;
  assign fill    = (state_q == CTL_FETCH) && mem_ready;

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assoc2_way_bank #(
      .SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (look_set),
      .cmp_tag  (look_tag),
      .rd_valid (way_valid[w]),
      .match    (way_match[w]),
      .rd_data  (way_data[w]),
      .wr_en    (fill && (fway_q == w[0])),
      .wr_set   (fill_set),
      .wr_tag   (fill_tag),
      .wr_data  (mem_rdata)
    );
  end

  assoc2_lru_pick #(.SETS(SETS), .SET_W(SET_W)) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_set  (look_set),
    .look_v0   (way_valid[0]),
    .look_v1   (way_valid[1]),
    .victim    (victim),
    .touch_en  (rsp_ready),
    .touch_set (fill ? fill_set : look_set),
    .touch_way (fill ? fway_q : way_match[1])
  );

  // Next-state and capture enables
  always_comb begin
    state_d = state_q;
    fadr_d  = fadr_q;
    fway_d  = fway_q;
    unique case (state_q)
      CTL_IDLE: if (lookup && !any_hit) begin
        state_d = CTL_FETCH;
        fadr_d  = req_addr;
        fway_d  = victim;
      end
      CTL_FETCH: if (mem_ready) state_d = CTL_IDLE;
      default: state_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CTL_IDLE;
      fadr_q  <= '0;
      fway_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fadr_q  <= fadr_d;
      fway_q  <= fway_d;
    end
  end

  assign rsp_hit   = lookup && any_hit;
  assign rsp_ready = rsp_hit || fill;
  assign rsp_data  = fill ? mem_rdata : (way_match[1] ? way_data[1] : way_data[0]);
  assign mem_valid = (state_q == CTL_FETCH);
  assign mem_addr  = fadr_q;

  // R2
  single_way_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lookup |-> $onehot0(way_match));
  // R3
  hit_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_ready && !mem_valid));
  // R4
  fetch_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
  // R5
  fill_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |-> (rsp_ready && !rsp_hit && rsp_data == mem_rdata));
  // R5
  fill_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> !mem_valid);
endmodule

// File: tb/assoc2_rd_cache_test.sv
module assoc2_rd_cache_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int NS = 2;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          rsp_ready, rsp_hit;
  logic [DW-1:0] rsp_data;
  logic          mem_valid;
  logic [AW-1:0] mem_addr;
  logic          mem_ready;
  logic [DW-1:0] mem_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Bench model of cache state
  bit       mv  [NS][2];
  int       mt  [NS][2];
  bit       mlru[NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  assoc2_rd_cache #(.ADDR_W(AW), .SETS(NS), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  function automatic logic [DW-1:0] word_of(input int a);
    return DW'((a * 29 + 7) & 8'hFF);
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < NS; s++) begin
      mv[s][0] = 0; mv[s][1] = 0; mlru[s] = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0; mem_ready = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    check(rsp_ready == 1'b0, "R1 rsp_ready in reset", rsp_ready, 0);
    check(mem_valid == 1'b0, "R1 mem_valid in reset", mem_valid, 0);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk); #1;
    check(rsp_ready == 1'b0, "R1 rsp_ready after reset", rsp_ready, 0);
    check(mem_valid == 1'b0, "R1 mem_valid after reset", mem_valid, 0);
  endtask

  // One blocking access; returns whether it hit.
  task automatic access(input int a, input int lat, output bit was_hit);
    int  s, t, hw, vw;
    bit  exp_hit;
    s = a % NS;
    t = a / NS;
    exp_hit = 0; hw = 0;
    for (int w = 0; w < 2; w++)
      if (mv[s][w] && mt[s][w] == t) begin exp_hit = 1; hw = w; end
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = AW'(a);
    #1;
    was_hit = rsp_hit;
    check(rsp_hit == exp_hit, "R2 R3 hit flag (R6 R7 via state)", rsp_hit, exp_hit);
    if (exp_hit) begin
      check(rsp_ready == 1'b1, "R3 ready on hit", rsp_ready, 1);
      check(rsp_data == word_of(a), "R3 hit data", rsp_data, word_of(a));
      check(mem_valid == 1'b0, "R3 no fetch on hit", mem_valid, 0);
      mlru[s] = ~hw[0];
      @(negedge clk);
      req_valid = 1'b0;
    end else begin
      check(rsp_ready == 1'b0, "R4 ready low on miss", rsp_ready, 1'b0);
      @(negedge clk); #1;
      check(mem_valid == 1'b1, "R4 fetch issued", mem_valid, 1);
      check(mem_addr == AW'(a), "R4 fetch address", mem_addr, a);
      for (int k = 0; k < lat; k++) begin
        check(rsp_ready == 1'b0 && mem_valid == 1'b1 && mem_addr == AW'(a),
              "R4 held while waiting", {mem_valid, rsp_ready}, 2);
        @(negedge clk); #1;
      end
      mem_ready = 1'b1;
      mem_rdata = word_of(a);
      #1;
      check(rsp_ready == 1'b1 && rsp_hit == 1'b0, "R5 fill response", {rsp_ready, rsp_hit}, 2);
      check(rsp_data == word_of(a), "R5 fill data", rsp_data, word_of(a));
      if (!mv[s][0])      vw = 0;
      else if (!mv[s][1]) vw = 1;
      else                vw = int'(mlru[s]);
      mv[s][vw] = 1; mt[s][vw] = t; mlru[s] = ~vw[0];
      @(negedge clk);
      mem_ready = 1'b0;
      req_valid = 1'b0;
      #1;
      check(mem_valid == 1'b0, "R5 idle after fill", mem_valid, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit h;
    int seq [5] = '{0, 8, 0, 6, 8};
    bit exp_seq [5] = '{0, 0, 1, 0, 0};
    int lfsr;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; mem_ready = 1'b0; mem_rdata = '0;
    model_clear();
    do_reset();

    // R8: the stated block sequence
    for (int i = 0; i < 5; i++) begin
      access(seq[i], i % 3, h);
      check(h == exp_seq[i], "R8 sequence outcome", h, exp_seq[i]);
    end
    // R6: 8 was displaced by 6, then 0 by 8: 6 and 8 remain, 0 gone
    access(6, 0, h); check(h == 1'b1, "R6 block 6 kept", h, 1);
    access(8, 0, h); check(h == 1'b1, "R6 block 8 kept", h, 1);
    access(0, 1, h); check(h == 1'b0, "R6 block 0 evicted", h, 0);

    // R1: reset mid-run empties every set
    do_reset();
    for (int a = 0; a < (1 << AW); a++) begin
      access(a, a % 4, h);
      if (a < 2 * NS) check(h == 1'b0, "R1 first access misses", h, 0);
    end
    // R2: sweep again, the last two tags of each set remain
    for (int a = 0; a < (1 << AW); a++) access(a, (a + 1) % 4, h);

    // Pseudo-random stream with varied latency
    lfsr = 5;
    for (int i = 0; i < 400; i++) begin
      lfsr = (lfsr * 13 + 7) % 251;
      access(lfsr % (1 << AW), i % 4, h);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule